// File: doc/BRIEF.md
# Crosswise GF(2^8) Column Mixer

This block applies the AES column-mixing transform, or its inverse, to one 32-bit state column. A single mode input picks the direction. Each constant multiplication inside the 4x4 matrix product uses a vertically-crosswise multiplier. In that multiplier, every operand bit pair is ANDed into a partial product. The partial products on each anti-diagonal are XORed into one bit of a 15-bit carry-less product. That raw product is then folded down to 8 bits modulo the field polynomial.

Forward and inverse share the same multiplier structure; only the coefficient bytes fed to it differ. A parameter adds one output register stage. With the register present, the result of a column and mode presented before a rising edge appears at `col_out` after that edge. A larger datapath sequences the four columns of a state through the unit.

Top module: `xmix_column`

## Requirements
- R1: Byte order is fixed: `col_in[31:24]` is row 0 and `col_in[7:0]` is row 3, and `col_out` uses the same order. With `mode_inv`=0, output row r is the field sum over c of coef(r,c)·in[c], where row 0 has coefficients {02,03,01,01} and each following row is the previous row rotated right by one byte.
- R2: With `mode_inv`=1, the same structure is used with row 0 coefficients {0E,0B,0D,09}, again rotated right by one byte per row.
- R3: Applying the inverse transform to the output of the forward transform returns the original column, for any column.
- R4: With `OUT_REG`=1, `col_out` changes only at a rising clock edge. It then shows the transform of the `col_in` and `mode_inv` values sampled at that edge, and holds that value while the inputs change between edges.
- R5: A synchronous active-high `rst` drives `col_out` to zero at the next rising edge.
- R6: Field products are carry-less products reduced modulo x^8+x^4+x^3+x+1 (0x11B). A column with one non-zero byte v at row p yields, in each output row, the product of v and that row's coefficient for column p.
- R7: The transform is linear over XOR: the all-zero column maps to zero, and out(a^b) = out(a)^out(b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_inv | input | 1 | 0 = forward mix, 1 = inverse mix |
| col_in | input | 32 | Input column, row 0 in the top byte |
| col_out | output | 32 | Mixed column, registered when OUT_REG=1 |

## Verification
The bench feeds every value of a single non-zero byte into every row position in both modes. This catches a wrong anti-diagonal in the crosswise array or a missed fold step in the reduction: either one corrupts products whose high bits are set, such as those of 0x80 or 0xFF. A rotation in the wrong direction or a swapped inverse coefficient shows up as a byte in the wrong row. Random columns are run through forward and then inverse and must come back unchanged. Linearity checks, a reset in the middle of the run and a hold check between edges cover XOR combining, clearing and the register timing.

// File: rtl/xmix_pkg.sv
package xmix_pkg;

    localparam int GF_W   = 8;
    localparam int ROWS   = 4;
    localparam int RAW_W  = 2 * GF_W - 1;
    localparam int COL_W  = ROWS * GF_W;
    localparam logic [GF_W:0] GF_POLY = 9'h11B;

    typedef logic [GF_W-1:0] gf_t;
    typedef logic [RAW_W-1:0] gf_raw_t;

    typedef struct packed {
        gf_t r0;
        gf_t r1;
        gf_t r2;
        gf_t r3;
    } column_t;

    typedef enum logic {
        MIX_FWD = 1'b0,
        MIX_INV = 1'b1
    } mix_mode_e;

    // Row-0 coefficients; later rows rotate right by one byte each.
    function automatic gf_t base_coef(input mix_mode_e mode, input int idx);
        gf_t fwd [ROWS] = '{8'h02, 8'h03, 8'h01, 8'h01};
        gf_t inv [ROWS] = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
        return (mode == MIX_INV) ? inv[idx] : fwd[idx];
    endfunction

    function automatic gf_t mat_coef(input mix_mode_e mode, input int row, input int col);
        return base_coef(mode, (col - row + ROWS) % ROWS);
    endfunction

    // Fold the 15-bit carry-less product modulo the field polynomial.
    function automatic gf_t gf_fold(input gf_raw_t raw);
        gf_raw_t t;
        t = raw;
        for (int k = RAW_W - 1; k >= GF_W; k--) begin
            if (t[k]) begin
                t = t ^ (gf_raw_t'(GF_POLY) << (k - GF_W));
            end
        end
        return t[GF_W-1:0];
    endfunction

    function automatic gf_t col_byte(input column_t c, input int idx);
        logic [COL_W-1:0] flat;
        flat = c;
        return flat[COL_W-1-idx*GF_W -: GF_W];
    endfunction

endpackage

// File: rtl/gf_cross_mul.sv
module gf_cross_mul
    import xmix_pkg::*;
(
    input  gf_t a,
    input  gf_t b,
    output gf_t p
);

    logic [GF_W-1:0][GF_W-1:0] pp;
    gf_raw_t raw;

    // Partial-product array: every operand bit pair ANDed.
    for (genvar i = 0; i < GF_W; i++) begin : g_row
        for (genvar j = 0; j < GF_W; j++) begin : g_col
            assign pp[i][j] = a[i] & b[j];
        end
    end

    // Crosswise column sums: each anti-diagonal collapses through XOR.
    always_comb begin
        raw = '0;
        for (int k = 0; k < RAW_W; k++) begin
            for (int i = 0; i < GF_W; i++) begin
                if ((k - i) >= 0 && (k - i) < GF_W) begin
                    raw[k] = raw[k] ^ pp[i][k-i];
                end
            end
        end
    end

    assign p = gf_fold(raw);

    // R6: multiplicative identity and zero annihilator.
    always_comb begin
        if (b == 8'h01) begin
            a_r6_unit: assert (p == a);
        end
        if (a == '0 || b == '0) begin
            a_r6_zero: assert (p == '0);
        end
    end

endmodule

// File: rtl/xmix_row.sv
module xmix_row
    import xmix_pkg::*;
#(
    parameter int ROW = 0
) (
    input  column_t   col,
    input  mix_mode_e mode,
    output gf_t       res
);

    gf_t prod [ROWS];

    for (genvar c = 0; c < ROWS; c++) begin : g_term
        gf_t coef;
        assign coef = mat_coef(mode, ROW, c);
        gf_cross_mul u_mul (
            .a (col_byte(col, c)),
            .b (coef),
            .p (prod[c])
        );
    end

    always_comb begin
        res = '0;
        for (int c = 0; c < ROWS; c++) begin
            res = res ^ prod[c];
        end
    end

endmodule

// File: rtl/xmix_column.sv
module xmix_column
    import xmix_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_inv,
    input  logic [31:0] col_in,
    output logic [31:0] col_out
);

    column_t   col;
    mix_mode_e mode;
    gf_t       row_res [ROWS];
    logic [COL_W-1:0] mixed;

    assign col  = column_t'(col_in);
    assign mode = mix_mode_e'(mode_inv);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        xmix_row #(.ROW(r)) u_row (
            .col  (col),
            .mode (mode),
            .res  (row_res[r])
        );
        assign mixed[COL_W-1-r*GF_W -: GF_W] = row_res[r];
    end

    // R1/R2: rows of each matrix sum to one, so a uniform column is fixed.
    always_comb begin
        if (col.r0 == col.r1 && col.r1 == col.r2 && col.r2 == col.r3) begin
            a_r1_uniform: assert (mixed == col_in);
        end
    end

    if (OUT_REG) begin : g_reg
        logic armed;

        always_ff @(posedge clk) begin
            if (rst) begin
                col_out <= '0;
                armed   <= 1'b0;
            end else begin
                col_out <= mixed;
                armed   <= 1'b1;
            end
        end

        a_r7_zero_in: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(col_in) == '0) |-> (col_out == '0));

        a_r4_hold: assert property (@(posedge clk) disable iff (rst || !armed)
            ($past(col_in) == col_in && $past(mode_inv) == mode_inv)
            |=> $stable(col_out));
    end else begin : g_comb
        assign col_out = mixed;
    end

endmodule

// File: tb/xmix_column_test.sv
module xmix_column_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_inv = 1'b0;
    logic [31:0] col_in = '0;
    logic [31:0] col_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xmix_column #(.OUT_REG(1'b1)) uut (
        .clk      (clk),
        .rst      (rst),
        .mode_inv (mode_inv),
        .col_in   (col_in),
        .col_out  (col_out)
    );

    // Independent reference: shift-and-conditional-XOR doubling.
    function automatic logic [7:0] dbl(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] v, input logic [7:0] k);
        logic [7:0] acc = 8'h00;
        logic [7:0] cur = v;
        for (int i = 0; i < 8; i++) begin
            if (k[i]) acc = acc ^ cur;
            cur = dbl(cur);
        end
        return acc;
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] c, input bit inv);
        logic [7:0] k0 [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
        logic [7:0] k1 [4] = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
        logic [31:0] o = '0;
        for (int r = 0; r < 4; r++) begin
            logic [7:0] s = 8'h00;
            for (int j = 0; j < 4; j++) begin
                logic [7:0] kk = inv ? k1[(j - r + 4) % 4] : k0[(j - r + 4) % 4];
                s = s ^ gmul(c[31-8*j -: 8], kk);
            end
            o[31-8*r -: 8] = s;
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge load the register.
    task automatic apply(input logic [31:0] c, input bit inv);
        @(negedge clk);
        col_in   = c;
        mode_inv = inv;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog got=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [31:0] lfsr = 32'hACE1_2468;
    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        col_in = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1;
        check("R5 reset", col_out, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1/R2/R6: every single-byte column in every row, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                for (int v = 0; v < 256; v++) begin
                    logic [31:0] c = 32'(v) << (24 - 8*p);
                    apply(c, m[0]);
                    check(m == 0 ? "R1 R6 fwd single" : "R2 R6 inv single",
                          col_out, ref_mix(c, m[0]));
                end
            end
        end

        // Known column: db 13 53 45 -> 8e 4d a1 bc under the forward mix.
        apply(32'hDB13_5345, 1'b0);
        check("R1 known", col_out, 32'h8E4D_A1BC);
        apply(32'h8E4D_A1BC, 1'b1);
        check("R2 known", col_out, 32'hDB13_5345);

        // R3: random columns round-trip through forward then inverse.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] orig;
            logic [31:0] fwd;
            lfsr = step(lfsr);
            orig = lfsr;
            apply(orig, 1'b0);
            fwd = col_out;
            check("R1 random", fwd, ref_mix(orig, 1'b0));
            apply(fwd, 1'b1);
            check("R3 round trip", col_out, orig);
        end

        // R7: zero and XOR linearity in both modes.
        for (int m = 0; m < 2; m++) begin
            apply(32'h0, m[0]);
            check("R7 zero", col_out, 32'h0);
            for (int n = 0; n < 40; n++) begin
                logic [31:0] a;
                logic [31:0] b;
                logic [31:0] oa;
                logic [31:0] ob;
                lfsr = step(lfsr); a = lfsr;
                lfsr = step(lfsr); b = lfsr;
                apply(a, m[0]); oa = col_out;
                apply(b, m[0]); ob = col_out;
                apply(a ^ b, m[0]);
                check("R7 linear", col_out, oa ^ ob);
            end
        end

        // R4: output holds between edges, then updates at the edge.
        apply(32'h0102_0304, 1'b0);
        @(negedge clk);
        col_in   = 32'hF0E1_D2C3;
        mode_inv = 1'b1;
        #2;
        check("R4 hold", col_out, ref_mix(32'h0102_0304, 1'b0));
        @(posedge clk);
        #1;
        check("R4 update", col_out, ref_mix(32'hF0E1_D2C3, 1'b1));

        // R5: reset in mid-run clears the output at the next edge.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R5 mid reset", col_out, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        apply(32'h5555_AAAA, 1'b0);
        check("R5 resume", col_out, ref_mix(32'h5555_AAAA, 1'b0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule